// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation A/D converter with a parameterised resolution of 10 bits by default. It advances only on a conversion-clock enable pulse (one pulse per conversion period, called a TAD tick below). Software controls it through an enable level, a start/busy flag (set pulse and clear pulse), a 3-bit acquisition-time select, a result write port and an interrupt-flag clear. A compare unit can also start conversions through a trigger pulse that comes with a 4-bit compare-mode code.

A start can first run an automatic acquisition delay with the sample switch still closed. The sequencer then opens the switch and resolves the word MSB first. It presents each trial word to the external comparator, which is modelled here as a 1-bit input. When the last bit is resolved, it stores the word and raises the interrupt flag. An abort discards the partial word. After any completion or abort there is a fixed settling wait before the channel is sampled again. A matching trigger always emits a one-cycle timer-reset pulse.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and after its release, go_busy, irq_flag, tmr_rst, trial and result are 0 and sample_closed is 1.
- R2: A start moves the sequencer out of idle on the first clock edge after go_busy was set. The acquisition select then sets the delay in TAD ticks as follows: 000=0, 001=2, 010=4, 011=6, 100=8, 101=12, 110=16, 111=20. sample_closed stays 1 during the delay.
- R3: The conversion opens the sample switch (sample_closed=0) with trial = 10'h200 (MSB only set). Bits 9 down to 0 are then resolved one per TAD tick, and a bit is kept when cmp_in is 1. The whole conversion takes 11 TAD ticks, and with an ideal comparator the result equals the analog value.
- R4: On the 11th conversion tick the result is loaded, go_busy falls, irq_flag rises and sample_closed returns to 1, all at that same clock edge.
- R5: A go_clr pulse while go_busy is 1 during acquisition or conversion aborts at the next edge. go_busy drops and sample_closed becomes 1, while result and irq_flag stay unchanged.
- R6: After a completion or an abort the sequencer waits 2 TAD ticks. A start requested during this wait takes effect at the second wait tick, followed by the selected acquisition delay.
- R7: trig with trig_mode = 4'b1011 while enabled sets go_busy at the next edge and starts a conversion. It also makes tmr_rst 1 for exactly one cycle after that edge.
- R8: trig with trig_mode = 4'b1011 while cfg_en is 0 still pulses tmr_rst but leaves go_busy at 0. trig with any other trig_mode does neither.
- R9: go_set has no effect while cfg_en is 0, or in the cycle in which cfg_en goes from 0 to 1.
- R10: res_wr loads res_wdata into result only while go_busy is 0. It is ignored while go_busy is 1.
- R11: irq_flag stays 1 until flag_clr. A completion in the same cycle as flag_clr leaves irq_flag at 1.
- R12: Dropping cfg_en clears go_busy at the next edge, closes the sample switch, forces trial to 0 and keeps result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tad_en | input | 1 | Conversion-clock enable, one pulse per TAD |
| cfg_en | input | 1 | Converter enable |
| go_set | input | 1 | Software pulse that sets the busy flag |
| go_clr | input | 1 | Software pulse that clears the busy flag (abort) |
| acq_sel | input | 3 | Acquisition delay select |
| trig | input | 1 | Special-event trigger pulse from a compare unit |
| trig_mode | input | 4 | Compare-mode code of the trigger source |
| cmp_in | input | 1 | Comparator output, 1 when input >= trial |
| res_wr | input | 1 | Software write strobe for the result |
| res_wdata | input | 10 | Software write data for the result |
| flag_clr | input | 1 | Software pulse that clears the interrupt flag |
| go_busy | output | 1 | Start/busy flag |
| sample_closed | output | 1 | Sample switch control, 1 = connected |
| trial | output | 10 | Trial word to the DAC, 0 outside conversion |
| result | output | 10 | Result register |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| tmr_rst | output | 1 | One-cycle timer-reset pulse |

## Verification
The bench counts TAD ticks from each start and checks the exact tick at which the switch opens and the one at which busy falls, for every acquisition code and for random tick periods. An off-by-one delay or conversion count moves one of these edges. Aborts are issued in both acquisition and conversion, and each is followed at once by a restart. A design that loaded the partial word, set the flag or skipped the settling wait would show a changed result or a short tick count. The bench also exercises a trigger while disabled, a start in the enable-rise cycle, a write while busy and a flag clear that coincides with completion. Each of these exposes a design that lets the wrong event win.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;

  // compare-mode code that routes a trigger into the converter
  localparam logic [3:0] TRIG_CODE = 4'b1011;

  // automatic acquisition delay in TAD ticks per select code
  function automatic logic [4:0] acq_ticks(input logic [2:0] sel);
    logic [4:0] r;
    case (sel)
      3'd0:    r = 5'd0;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd6;
      3'd4:    r = 5'd8;
      3'd5:    r = 5'd12;
      3'd6:    r = 5'd16;
      default: r = 5'd20;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sar_seq_trig.sv
`timescale 1ns/1ps
module sar_seq_trig
  import sar_seq_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [MODE_W-1:0] trig_mode,
  output logic              hit,
  output logic              tmr_rst_q
);

  logic tmr_rst_n;

  always_comb begin
    hit       = trig && (trig_mode == MODE_W'(TRIG_CODE));
    tmr_rst_n = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_rst_q <= 1'b0;
    else        tmr_rst_q <= tmr_rst_n;
  end

endmodule

// File: rtl/sar_seq_sar.sv
`timescale 1ns/1ps
module sar_seq_sar #(
  parameter int RES_W = 10,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] idx,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial_q,
  output logic [RES_W-1:0] word_n
);

  always_comb begin
    word_n = trial_q;
    if (load) begin
      word_n = '0;
      word_n[RES_W-1] = 1'b1;
    end else if (step) begin
      for (int b = 0; b < RES_W; b++) begin
        if (idx == CNT_W'(b))          word_n[b] = cmp_in;
        else if (idx == CNT_W'(b + 1)) word_n[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           trial_q <= '0;
    else if (load | step) trial_q <= word_n;
  end

endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = 10,
  parameter int WAIT_TAD = 2,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tad_en,
  input  logic             cfg_en,
  input  logic             go_req,
  input  logic             go_clr,
  input  logic [2:0]       acq_sel,
  output logic             go_q,
  output logic             conv,
  output logic             sar_load,
  output logic             sar_step,
  output logic [CNT_W-1:0] step_idx,
  output logic             finish
);

  seq_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] dly_q, dly_n;
  logic [CNT_W-1:0] dly_sel;
  logic             go_n;
  logic             en_q;

  always_comb begin
    dly_sel  = CNT_W'(acq_ticks(acq_sel));
    step_idx = CNT_W'(RES_W) - cnt_q;
    conv     = (st_q == ST_CONV);
  end

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    dly_n    = dly_q;
    go_n     = go_q;
    sar_load = 1'b0;
    sar_step = 1'b0;
    finish   = 1'b0;
    if (!cfg_en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      go_n  = 1'b0;
    end else if (go_clr && go_q) begin
      go_n = 1'b0;
      if (st_q == ST_ACQ || st_q == ST_CONV) begin
        st_n  = ST_WAIT;
        cnt_n = '0;
      end
    end else begin
      if (go_req && en_q && !go_q) go_n = 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (go_q) begin
            cnt_n = '0;
            dly_n = dly_sel;
            if (dly_sel == '0) begin
              st_n     = ST_CONV;
              sar_load = 1'b1;
            end else begin
              st_n = ST_ACQ;
            end
          end
        end
        ST_ACQ: begin
          if (tad_en) begin
            if ((cnt_q + CNT_W'(1)) == dly_q) begin
              st_n     = ST_CONV;
              cnt_n    = '0;
              sar_load = 1'b1;
            end else begin
              cnt_n = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_CONV: begin
          if (tad_en) begin
            if (cnt_q != '0) sar_step = 1'b1;
            if (cnt_q == CNT_W'(RES_W)) begin
              finish = 1'b1;
              go_n   = 1'b0;
              st_n   = ST_WAIT;
              cnt_n  = '0;
            end else begin
              cnt_n = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          if (tad_en) begin
            if (cnt_q == CNT_W'(WAIT_TAD - 1)) begin
              cnt_n = '0;
              if (go_q) begin
                dly_n = dly_sel;
                if (dly_sel == '0) begin
                  st_n     = ST_CONV;
                  sar_load = 1'b1;
                end else begin
                  st_n = ST_ACQ;
                end
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              cnt_n = cnt_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      dly_q <= '0;
      go_q  <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      dly_q <= dly_n;
      go_q  <= go_n;
      en_q  <= cfg_en;
    end
  end

endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int RES_W    = 10,
  parameter int WAIT_TAD = 2,
  parameter int MODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tad_en,
  input  logic              cfg_en,
  input  logic              go_set,
  input  logic              go_clr,
  input  logic [2:0]        acq_sel,
  input  logic              trig,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic              cmp_in,
  input  logic              res_wr,
  input  logic [RES_W-1:0]  res_wdata,
  input  logic              flag_clr,
  output logic              go_busy,
  output logic              sample_closed,
  output logic [RES_W-1:0]  trial,
  output logic [RES_W-1:0]  result,
  output logic              irq_flag,
  output logic              tmr_rst
);

  localparam int CMAX  = (RES_W > 20) ? RES_W : 20;
  localparam int CNT_W = $clog2(CMAX + 1);

  logic             trig_hit;
  logic             go_q, conv, sar_load, sar_step, finish;
  logic [CNT_W-1:0] step_idx;
  logic [RES_W-1:0] trial_q, word_n;
  logic [RES_W-1:0] res_q, res_n;
  logic             flag_q, flag_n;

  sar_seq_trig #(.MODE_W(MODE_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .trig_mode (trig_mode),
    .hit       (trig_hit),
    .tmr_rst_q (tmr_rst)
  );

  sar_seq_ctrl #(.RES_W(RES_W), .WAIT_TAD(WAIT_TAD), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tad_en   (tad_en),
    .cfg_en   (cfg_en),
    .go_req   (go_set | trig_hit),
    .go_clr   (go_clr),
    .acq_sel  (acq_sel),
    .go_q     (go_q),
    .conv     (conv),
    .sar_load (sar_load),
    .sar_step (sar_step),
    .step_idx (step_idx),
    .finish   (finish)
  );

  sar_seq_sar #(.RES_W(RES_W), .CNT_W(CNT_W)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sar_load),
    .step    (sar_step),
    .idx     (step_idx),
    .cmp_in  (cmp_in),
    .trial_q (trial_q),
    .word_n  (word_n)
  );

  always_comb begin
    res_n = res_q;
    if (finish)             res_n = word_n;
    else if (res_wr && !go_q) res_n = res_wdata;
    flag_n = flag_q;
    if (flag_clr) flag_n = 1'b0;
    if (finish)   flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      res_q  <= res_n;
      flag_q <= flag_n;
    end
  end

  assign go_busy       = go_q;
  assign sample_closed = !conv;
  assign trial         = conv ? trial_q : '0;
  assign result        = res_q;
  assign irq_flag      = flag_q;

endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int RES_W  = 10,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              go_clr,
  input logic              trig,
  input logic [MODE_W-1:0] trig_mode,
  input logic              res_wr,
  input logic              go_busy,
  input logic              sample_closed,
  input logic [RES_W-1:0]  result,
  input logic              irq_flag,
  input logic              tmr_rst
);

  p_open_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_closed |-> go_busy);

  p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go_busy) && !go_busy && !$past(go_clr) && $past(cfg_en)) |-> irq_flag);

  p_abort_keeps_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(go_busy) && $past(go_clr) && $past(cfg_en)) |-> $stable(result));

  p_trig_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && trig_mode == MODE_W'(4'b1011)) |=> tmr_rst);

  p_tmr_needs_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |-> $past(trig));

  p_result_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> ($past(go_busy) || $past(res_wr)));

  p_disable_idles_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!go_busy && sample_closed));

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .MODE_W(MODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_en        (cfg_en),
  .go_clr        (go_clr),
  .trig          (trig),
  .trig_mode     (trig_mode),
  .res_wr        (res_wr),
  .go_busy       (go_busy),
  .sample_closed (sample_closed),
  .result        (result),
  .irq_flag      (irq_flag),
  .tmr_rst       (tmr_rst)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tad_en = 1'b0;
  logic       cfg_en, go_set, go_clr, trig, res_wr, flag_clr;
  logic [2:0] acq_sel;
  logic [3:0] trig_mode;
  logic [9:0] res_wdata, analog;
  logic       cmp_in;
  logic       go_busy, sample_closed, irq_flag, tmr_rst;
  logic [9:0] trial, result;

  int  tests = 0;
  int  fails = 0;
  int  cyc   = 0;
  bit  done  = 1'b0;
  int  tad_p = 4;
  int  tc    = 0;
  logic last_tick = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator
  assign cmp_in = (analog >= trial);

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tad_en(tad_en), .cfg_en(cfg_en),
    .go_set(go_set), .go_clr(go_clr), .acq_sel(acq_sel), .trig(trig),
    .trig_mode(trig_mode), .cmp_in(cmp_in), .res_wr(res_wr),
    .res_wdata(res_wdata), .flag_clr(flag_clr), .go_busy(go_busy),
    .sample_closed(sample_closed), .trial(trial), .result(result),
    .irq_flag(irq_flag), .tmr_rst(tmr_rst)
  );

  // TAD tick generator: updated shortly after each rising edge
  always @(posedge clk) begin
    #1;
    last_tick = tad_en;
    tc = (tc + 1 >= tad_p) ? 0 : tc + 1;
    tad_en = (tc == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_dly(input logic [2:0] s);
    case (s)
      3'd0: return 0;   3'd1: return 2;   3'd2: return 4;   3'd3: return 6;
      3'd4: return 8;   3'd5: return 12;  3'd6: return 16;  default: return 20;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(negedge clk);
      while (!last_tick) @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (go_busy && lim < 2000) begin @(negedge clk); lim++; end
  endtask

  // start and follow one conversion; b2b = start right after completion/abort
  task automatic run_conv(input logic [9:0] a, input logic [2:0] sel, input bit b2b);
    int cnt, open_at, exp_open, lim;
    logic n, lastn;
    analog  = a;
    acq_sel = sel;
    if (!b2b) begin
      wait_ticks(3);
      while (!last_tick) @(negedge clk);
    end
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    chk(go_busy === 1'b1, "R2 start accepted", go_busy, 1);
    exp_open = (b2b ? 2 : 0) + exp_dly(sel);
    cnt = 0; open_at = -1; lastn = 1'b0; lim = 0;
    while (go_busy && lim < 2000) begin
      n = tad_en;
      @(negedge clk);
      lim++;
      if (n) cnt++;
      lastn = n;
      if (!sample_closed && open_at < 0) begin
        open_at = cnt;
        chk(trial === 10'h200, "R3 MSB trial first", trial, 10'h200);
      end
    end
    chk(open_at == exp_open, "R2/R6 switch opens after delay", open_at, exp_open);
    chk(cnt == exp_open + 11 && lastn, "R3 conversion length", cnt, exp_open + 11);
    chk(result === a, "R3 result value", result, a);
    chk(irq_flag === 1'b1, "R4 flag on completion", irq_flag, 1);
    chk(sample_closed === 1'b1, "R4 switch reconnected", sample_closed, 1);
  endtask

  task automatic abort_conv(input logic [9:0] a, input logic [2:0] sel, input bit in_acq);
    logic [9:0] prev;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    analog = a; acq_sel = sel;
    wait_ticks(3);
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    if (in_acq) wait_ticks(1);
    else begin
      while (sample_closed) @(negedge clk);
      wait_ticks(3);
    end
    prev = result;
    go_clr = 1'b1; @(negedge clk); go_clr = 1'b0;
    chk(go_busy === 1'b0, "R5 abort clears busy", go_busy, 0);
    chk(sample_closed === 1'b1, "R5 abort closes switch", sample_closed, 1);
    chk(result === prev, "R5 abort keeps result", result, prev);
    chk(irq_flag === 1'b0, "R5 abort leaves flag", irq_flag, 0);
  endtask

  initial begin
    logic [9:0] prev;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_en = 1'b0; go_set = 1'b0; go_clr = 1'b0; trig = 1'b0;
    res_wr = 1'b0; flag_clr = 1'b0; acq_sel = 3'd0; trig_mode = 4'd0;
    res_wdata = '0; analog = '0;
    repeat (4) @(negedge clk);
    chk(go_busy === 1'b0 && irq_flag === 1'b0 && tmr_rst === 1'b0,
        "R1 reset flags", {go_busy, irq_flag, tmr_rst}, 0);
    chk(sample_closed === 1'b1 && trial === '0, "R1 reset switch/trial", trial, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result === '0, "R1 reset result", result, 0);
    cfg_en = 1'b1;
    repeat (3) @(negedge clk);

    // directed conversions
    run_conv(10'h3FF, 3'd0, 1'b0);
    run_conv(10'h000, 3'd2, 1'b0);
    run_conv(10'h155, 3'd7, 1'b1);

    // R11: flag persists, clears, and completion beats a simultaneous clear
    repeat (10) @(negedge clk);
    chk(irq_flag === 1'b1, "R11 flag held", irq_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(irq_flag === 1'b0, "R11 flag cleared", irq_flag, 0);
    flag_clr = 1'b1;
    run_conv(10'h2C3, 3'd1, 1'b0);
    flag_clr = 1'b0;

    // R10: result writes
    wait_ticks(3);
    res_wdata = 10'h2AA; res_wr = 1'b1; @(negedge clk); res_wr = 1'b0;
    chk(result === 10'h2AA, "R10 write while idle", result, 10'h2AA);
    analog = 10'h0F3; acq_sel = 3'd0;
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    res_wdata = 10'h111; res_wr = 1'b1; @(negedge clk); res_wr = 1'b0;
    chk(result === 10'h2AA, "R10 write while busy ignored", result, 10'h2AA);
    wait_idle();
    chk(result === 10'h0F3, "R10 conversion after ignored write", result, 10'h0F3);

    // R5/R6: aborts followed by immediate restart
    abort_conv(10'h123, 3'd0, 1'b0);
    run_conv(10'h2E1, 3'd0, 1'b1);
    abort_conv(10'h321, 3'd3, 1'b1);
    run_conv(10'h08F, 3'd4, 1'b1);

    // R7: trigger while enabled
    wait_ticks(3);
    analog = 10'h3A5; acq_sel = 3'd0; trig_mode = 4'b1011;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk(tmr_rst === 1'b1, "R7 timer reset pulse", tmr_rst, 1);
    chk(go_busy === 1'b1, "R7 trigger starts", go_busy, 1);
    @(negedge clk);
    chk(tmr_rst === 1'b0, "R7 pulse one cycle", tmr_rst, 0);
    wait_idle();
    chk(result === 10'h3A5, "R7 triggered result", result, 10'h3A5);

    // R8: trigger while disabled, and wrong mode code
    wait_ticks(3);
    cfg_en = 1'b0; @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk(tmr_rst === 1'b1, "R8 timer reset while disabled", tmr_rst, 1);
    chk(go_busy === 1'b0, "R8 no start while disabled", go_busy, 0);
    cfg_en = 1'b1; repeat (2) @(negedge clk);
    trig_mode = 4'b1010;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk(tmr_rst === 1'b0, "R8 other mode no pulse", tmr_rst, 0);
    chk(go_busy === 1'b0, "R8 other mode no start", go_busy, 0);

    // R9: start ignored while disabled and on the enable-rise cycle
    cfg_en = 1'b0; @(negedge clk);
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    chk(go_busy === 1'b0, "R9 start ignored while disabled", go_busy, 0);
    cfg_en = 1'b1; go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    chk(go_busy === 1'b0, "R9 start ignored on enable rise", go_busy, 0);
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    chk(go_busy === 1'b1, "R9 start accepted once enabled", go_busy, 1);
    wait_idle();

    // R12: disable during conversion
    wait_ticks(3);
    analog = 10'h1C7; acq_sel = 3'd0;
    go_set = 1'b1; @(negedge clk); go_set = 1'b0;
    wait_ticks(4);
    prev = result;
    cfg_en = 1'b0; @(negedge clk);
    chk(go_busy === 1'b0 && sample_closed === 1'b1, "R12 disable idles",
        {go_busy, sample_closed}, 1);
    chk(trial === '0, "R12 trial cleared", trial, 0);
    chk(result === prev, "R12 result kept", result, prev);
    cfg_en = 1'b1; repeat (2) @(negedge clk);

    // random conversions over all codes and TAD periods
    run_conv(10'h200, 3'd5, 1'b0);
    for (int i = 0; i < 24; i++) begin
      tad_p = 3 + int'($urandom % 4);
      run_conv(10'($urandom), 3'($urandom), bit'($urandom % 2));
    end
    run_conv(10'h1FF, 3'd6, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule